// File: doc/BRIEF.md
# Thirty-Two Line General-Purpose I/O Port With Edge Interrupts

This block is a bank of 32 general-purpose I/O lines that sits on a simple 32-bit register bus. Each line can be an input or an output, and each output can be driven push-pull or open-drain. The data register can be written to set output values and read to see the line states. Input pins pass through a synchroniser, and the data register shows them only where the per-line input enable is set. The block does not contain the pad drivers. It presents a per-line output value and a per-line output enable that the pad ring uses.

Every line watches its synchronised pin for transitions. A per-line sense bit selects whether any edge or only a falling edge counts. A detected transition sets a sticky event bit, and software clears that bit by writing a 1 to it. A single interrupt output is raised while any event bit has its mask bit set. Bus words are bit-reversed relative to line numbers, so line 0 is the most significant bit of every register.

Top module: `pio_bank`

## Requirements
- R1: After reset every register reads 0, no line is driven (`pin_oe` all 0), `pin_out` is 0 and `irq_out` is low.
- R2: Line n occupies bus bit 31-n in every register. Byte offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, sense 0x14, input enable 0x18.
- R3: A direction bit of 1 makes the line an output: `pin_oe[n]` is 1 (push-pull case) and `pin_out[n]` follows the data register bit of that line.
- R4: A data register read returns the written value for output lines. For input lines it returns the two-flop-synchronised pin when that line's input-enable bit is 1, and 0 otherwise.
- R5: Direction, open-drain, mask, sense and input-enable registers read back what was written. Unmapped offsets read 0 and writes to them change nothing. `bus_rdata` is 0 while `bus_rd` is low.
- R6: For an output line with its open-drain bit set, `pin_oe` is 1 only while the data bit is 0, and the line is released while the data bit is 1.
- R7: With sense bit 0, both a rising and a falling edge of the synchronised pin set the line's event bit. The event becomes visible three clock edges after the pin changes, whatever the direction or input-enable of the line.
- R8: `irq_out` is high exactly when the bitwise AND of the event and mask registers is nonzero.
- R9: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R10: With sense bit 1, a rising edge leaves the event bit clear and a falling edge sets it.
- R11: If an edge is detected on a line in the same cycle that its event bit is written with 1, the event bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per word write |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` |
| bus_addr | input | 5 | Word-aligned byte offset |
| bus_wdata | input | 32 | Write data, bus bit order |
| bus_rdata | output | 32 | Read data, bus bit order, combinational from `bus_addr` |
| pin_in | input | 32 | Pad input values, index = line number |
| pin_out | output | 32 | Output values to pads, index = line number |
| pin_oe | output | 32 | Output enables to pads, index = line number |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is the collision in R11. There, the edge detector reports a transition on the same clock edge at which a write-1-to-clear reaches the same event bit. The stimulus changes the pin just after an edge and lets two further edges pass through the synchroniser. It then launches the clear write so that it lands on the third edge, which is the edge at which the detector fires. The falling-only sense mode is also driven both ways on one line, so that a missing event on the rising edge is told apart from a slow synchroniser.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int LINES  = 32;
    localparam int AW     = 5;
    localparam int SYNC_N = 2;

    typedef logic [LINES-1:0] lvec_t;

    typedef enum logic [AW-1:0] {
        OFS_DIR = 5'h00,
        OFS_OD  = 5'h04,
        OFS_DAT = 5'h08,
        OFS_EVT = 5'h0C,
        OFS_MSK = 5'h10,
        OFS_SNS = 5'h14,
        OFS_IBE = 5'h18
    } reg_ofs_e;

    // Configuration state, all vectors indexed by line number.
    typedef struct packed {
        lvec_t dir;
        lvec_t od;
        lvec_t dat;
        lvec_t msk;
        lvec_t sns;
        lvec_t ibe;
    } cfg_t;

    // Convert between bus bit order and line order (self-inverse).
    function automatic lvec_t flip(input lvec_t v);
        lvec_t r;
        for (int i = 0; i < LINES; i++) begin
            r[i] = v[LINES-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  lvec_t         wdata,
    input  lvec_t         pin_sync,
    input  lvec_t         ev,
    output cfg_t          cfg,
    output lvec_t         clr,
    output lvec_t         rdata
);

    lvec_t wl;
    lvec_t dat_view;
    lvec_t sel;

    assign wl = flip(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (addr)
                OFS_DIR: cfg.dir <= wl;
                OFS_OD:  cfg.od  <= wl;
                OFS_DAT: cfg.dat <= wl;
                OFS_MSK: cfg.msk <= wl;
                OFS_SNS: cfg.sns <= wl;
                OFS_IBE: cfg.ibe <= wl;
                default: ;
            endcase
        end
    end

    assign clr = (wr && addr == OFS_EVT) ? wl : '0;

    // Outputs show their latch; inputs show the gated synchronised pin.
    assign dat_view = (cfg.dir & cfg.dat) | (~cfg.dir & cfg.ibe & pin_sync);

    always_comb begin
        case (addr)
            OFS_DIR: sel = cfg.dir;
            OFS_OD:  sel = cfg.od;
            OFS_DAT: sel = dat_view;
            OFS_EVT: sel = ev;
            OFS_MSK: sel = cfg.msk;
            OFS_SNS: sel = cfg.sns;
            OFS_IBE: sel = cfg.ibe;
            default: sel = '0;
        endcase
    end

    assign rdata = rd ? flip(sel) : '0;

endmodule

// File: rtl/pio_edge.sv
module pio_edge #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] fall_only,
    output logic [W-1:0] sync,
    output logic [W-1:0] hit
);

    logic [STAGES-1:0][W-1:0] stg;
    logic [W-1:0]             prev;
    logic [W-1:0]             rise;
    logic [W-1:0]             fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= '0;
            prev <= '0;
        end else begin
            stg[0] <= pins;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
            prev <= stg[STAGES-1];
        end
    end

    assign sync = stg[STAGES-1];
    assign rise = sync & ~prev;
    assign fall = ~sync & prev;
    assign hit  = fall | (rise & ~fall_only);

endmodule

// File: rtl/pio_irq.sv
module pio_irq
    import pio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lvec_t hit,
    input  lvec_t clr,
    input  lvec_t msk,
    output lvec_t ev,
    output logic  irq
);

    // A fresh edge wins over a clear landing on the same bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            ev <= '0;
        end else begin
            ev <= (ev & ~clr) | hit;
        end
    end

    assign irq = |(ev & msk);

endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [31:0]   pin_in,
    output logic [31:0]   pin_out,
    output logic [31:0]   pin_oe,
    output logic          irq_out
);

    cfg_t  cfg;
    lvec_t clr;
    lvec_t ev;
    lvec_t hit;
    lvec_t pin_sync;

    pio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .ev       (ev),
        .cfg      (cfg),
        .clr      (clr),
        .rdata    (bus_rdata)
    );

    pio_edge #(.W(LINES), .STAGES(SYNC_N)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pins      (pin_in),
        .fall_only (cfg.sns),
        .sync      (pin_sync),
        .hit       (hit)
    );

    pio_irq u_irq (
        .clk (clk),
        .rst (rst),
        .hit (hit),
        .clr (clr),
        .msk (cfg.msk),
        .ev  (ev),
        .irq (irq_out)
    );

    assign pin_out = cfg.dat;
    assign pin_oe  = cfg.dir & ~(cfg.od & cfg.dat);

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
    import pio_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   pin_out,
    input logic [31:0]   pin_oe,
    input logic          irq_out,
    input lvec_t         ev,
    input lvec_t         hit,
    input lvec_t         od
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq_out));

    assert_od_never_high_R6: assert property (@(posedge clk) disable iff (rst)
        (od & pin_oe & pin_out) == '0);

    assert_clear_all_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_EVT && bus_wdata == '1 && hit == '0) |=> ev == '0);

    assert_edge_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((ev & $past(hit)) == $past(hit)));

    assert_no_spurious_event_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ev & ~$past(ev) & ~$past(hit)) == '0));

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(bus_wr) && $past(hit) == '0) |-> $stable(irq_out));

endmodule

bind pio_bank pio_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .ev        (ev),
    .hit       (hit),
    .od        (cfg.od)
);

// File: tb/pio_bank_test.sv
module pio_bank_test;
    import pio_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [31:0]   pin_in = '0;
    logic [31:0]   pin_out;
    logic [31:0]   pin_oe;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_bank uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [4:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    // Write then read back (R5); last entry is an unmapped offset.
    localparam vec_t VT [6] = '{
        '{5'h00, 32'h1234_5678, 32'h1234_5678},
        '{5'h04, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
        '{5'h10, 32'h0F0F_0000, 32'h0F0F_0000},
        '{5'h14, 32'hFFFF_0000, 32'hFFFF_0000},
        '{5'h18, 32'h00FF_00FF, 32'h00FF_00FF},
        '{5'h1C, 32'hDEAD_BEEF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(5'(a * 4), v);
            chk("R1 reg", v, 32'h0);
        end
        #1;
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);

        // R5: readback table
        for (int i = 0; i < 6; i++) begin
            wr(VT[i].a, VT[i].w);
            rd(VT[i].a, v);
            chk("R5 readback", v, VT[i].e);
        end
        @(negedge clk) bus_addr = 5'h00;
        #1 chk("R5 rd low", bus_rdata, 32'h0);
        for (int i = 0; i < 5; i++) wr(VT[i].a, 32'h0);

        // R2, R3: line 0 is bus bit 31
        wr(5'h00, 32'h8000_0000);
        wr(5'h08, 32'h8000_0000);
        #1;
        chk("R2 R3 pin_oe", pin_oe, 32'h0000_0001);
        chk("R2 R3 pin_out", pin_out, 32'h0000_0001);

        // R4: data view mixes outputs and gated inputs
        wr(5'h18, 32'h4000_0000);
        @(negedge clk) pin_in = 32'h0000_0006;
        idle(4);
        rd(5'h08, v);
        chk("R4 data ibe line1", v, 32'hC000_0000);
        wr(5'h18, 32'h6000_0000);
        rd(5'h08, v);
        chk("R4 data ibe lines1-2", v, 32'hE000_0000);

        // R6: open-drain on line 0
        wr(5'h04, 32'h8000_0000);
        #1 chk("R6 released on 1", pin_oe, 32'h0);
        wr(5'h08, 32'h0);
        #1 chk("R6 driven on 0", pin_oe, 32'h1);

        // Clear events left by the line 1/2 rises
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, v);
        chk("R9 clear all", v, 32'h0);

        // R7: any-edge on line 5, then R8 masking
        @(negedge clk) pin_in[5] = 1'b1;
        idle(4);
        rd(5'h0C, v);
        chk("R7 rise sets event", v, 32'h0400_0000);
        chk("R8 masked irq low", {31'b0, irq_out}, 32'h0);
        wr(5'h10, 32'h0400_0000);
        #1 chk("R8 unmasked irq high", {31'b0, irq_out}, 32'h1);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v);
        chk("R9 write 0 keeps", v, 32'h0400_0000);
        wr(5'h0C, 32'h0400_0000);
        rd(5'h0C, v);
        chk("R9 write 1 clears", v, 32'h0);
        chk("R8 irq low after clear", {31'b0, irq_out}, 32'h0);

        // R11: falling edge on line 5 lands with a clear write
        @(negedge clk) pin_in[5] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        wr(5'h0C, 32'h0400_0000);
        rd(5'h0C, v);
        chk("R11 edge beats clear", v, 32'h0400_0000);
        chk("R7 R8 fall raises irq", {31'b0, irq_out}, 32'h1);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, v);
        chk("R9 clear after collision", v, 32'h0);

        // R10: falling-only sense on line 6
        wr(5'h14, 32'h0200_0000);
        @(negedge clk) pin_in[6] = 1'b1;
        idle(5);
        rd(5'h0C, v);
        chk("R10 rise ignored", v, 32'h0);
        @(negedge clk) pin_in[6] = 1'b0;
        idle(5);
        rd(5'h0C, v);
        chk("R10 fall sets", v, 32'h0200_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule